// File: doc/BRIEF.md
# Statechart Configuration Update Engine

This block holds the active-state vector of a hierarchical statechart and computes, every clock, the configuration that follows from a vector of already-selected transitions. The chart's shape is fixed when the block is elaborated. Per-state tables give the parent index, the state kind and the declared default child. Per-transition tables give an exit mask and a target mask. Choosing transitions and evaluating guards happen upstream. This block only applies the choice.

Completion of entry is done in hardware. A state that is a transition target also enters all of its ancestors. A parallel state that enters takes all of its children with it. A compound state that enters, with no child targeted and no child staying active, enters its default child.

The per-state entry and exit strobes are combinational. They are valid during the cycle before the clock edge that loads the new configuration, so action logic can fire on them. The first step after reset enters the root's default configuration. A completion flag rises when a top-level final state is active.

Top module: `scfg_engine`

## Requirements
- R1: While reset is high the active vector and the completion flag are zero. In the first cycle after reset the root alone is forced into the entry set, and the default configuration is loaded at the following edge.
- R2: The exit strobe of a state is high exactly when the state is active and at least one selected transition has that state's bit set in its exit mask.
- R3: A state targeted by a selected transition is in the entry set, and so is every ancestor of that state.
- R4: Every child of a parallel state is in the entry set whenever the parallel state is in it.
- R5: A compound state in the entry set enters its declared default child. When the default-child field is 0 (none declared), it enters its lowest-numbered child.
- R6: Default entry of a compound state's child is suppressed when a child of that state stays active (active and not exiting) or is itself targeted or has a targeted descendant. At most one child of a compound state is ever active.
- R7: The entry strobe of a state is high when the state is in the entry set and is either inactive or exiting in the same step, so an exit-and-re-enter raises both strobes.
- R8: At each clock edge a state becomes active if it is in the entry set, or if it is active and not exiting. Otherwise it becomes inactive.
- R9: The completion flag is the OR of the active bits of the final states whose parent is the root. While it is high the root's next value is 0, so one edge after completion only the final state remains active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| selTrans | input | NT | One bit per selected transition for this step |
| activeVec | output | NS | Active-state register, bit i is state i |
| entryStrobe | output | NS | States entered by this step |
| exitStrobe | output | NS | States left by this step |
| completed | output | 1 | A top-level final state is active |

## Verification
The assertions assume that the selected set is consistent: every transition chosen has its source inside the active configuration, and no two chosen transitions exit overlapping regions. They also assume that nothing is selected once the completion flag is high. The stimulus keeps to this by deriving each choice from the bench's own model of the current configuration. It picks only transitions whose source is active. It combines transitions only across the two orthogonal regions of the parallel state. It drives an all-zero vector during the reset and completion steps.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  typedef enum logic [1:0] {
    KIND_ATOMIC   = 2'd0,
    KIND_COMPOUND = 2'd1,
    KIND_PARALLEL = 2'd2,
    KIND_FINAL    = 2'd3
  } stateKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic initStep;
    logic done;
  } stepCtrl_t;

  // default chart: 0 root, 1 par, 2 regA, 3 a1, 4 a2, 5 regB, 6 b1, 7 b2, 8 fin, 9 side
  localparam int DEF_NS = 10;
  localparam int DEF_NT = 9;
  localparam int DEF_IW = 4;

  localparam logic [DEF_NS*DEF_IW-1:0] DEF_PARENT =
    {4'd0, 4'd0, 4'd5, 4'd5, 4'd1, 4'd2, 4'd2, 4'd1, 4'd0, 4'd0};
  localparam logic [DEF_NS*2-1:0] DEF_KIND =
    {2'd0, 2'd3, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd1};
  localparam logic [DEF_NS*DEF_IW-1:0] DEF_INIT =
    {4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd4, 4'd0, 4'd1};
  localparam logic [DEF_NT*DEF_NS-1:0] DEF_EXIT = {
    10'b0000011100, 10'b1000000000, 10'b0011111110,
    10'b1000000000, 10'b0011111110, 10'b0010000000,
    10'b0001000000, 10'b0000001000, 10'b0000010000};
  localparam logic [DEF_NT*DEF_NS-1:0] DEF_TARGET = {
    10'b0000000100, 10'b0000000010, 10'b1000000000,
    10'b0000001000, 10'b0100000000, 10'b0001000000,
    10'b0010000000, 10'b0000010000, 10'b0000001000};

endpackage

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
#(
  parameter int NS = DEF_NS,
  parameter int IW = DEF_IW,
  parameter logic [NS*IW-1:0] PARENT_TBL = DEF_PARENT,
  parameter logic [NS*2-1:0] KIND_TBL = DEF_KIND
) (
  input  logic clk,
  input  logic rst,
  input  logic [NS-1:0] activeQ,
  output stepCtrl_t ctrl
);

  function automatic logic [NS-1:0] calcTopFinal();
    logic [NS-1:0] m;
    m = '0;
    for (int s = 1; s < NS; s++) begin
      if (KIND_TBL[2*s +: 2] == 2'(KIND_FINAL) && PARENT_TBL[s*IW +: IW] == '0)
        m[s] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NS-1:0] TOP_FINAL = calcTopFinal();

  logic initPending;

  always_ff @(posedge clk) begin
    if (rst) initPending <= 1'b1;
    else     initPending <= 1'b0;
  end

  assign ctrl.initStep = initPending;
  assign ctrl.done     = |(activeQ & TOP_FINAL);

  // R1: the forced first step brings the root up
  p_root_up_r1: assert property (@(posedge clk) disable iff (rst)
    ctrl.initStep |=> activeQ[0]);

  // R9: completion drops the root at the next edge
  p_done_root_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.done |=> !activeQ[0]);

endmodule

// File: rtl/scfg_datapath.sv
module scfg_datapath
  import scfg_pkg::*;
#(
  parameter int NS = DEF_NS,
  parameter int NT = DEF_NT,
  parameter int IW = DEF_IW,
  parameter logic [NS*IW-1:0] PARENT_TBL = DEF_PARENT,
  parameter logic [NS*2-1:0] KIND_TBL = DEF_KIND,
  parameter logic [NS*IW-1:0] INIT_TBL = DEF_INIT,
  parameter logic [NT*NS-1:0] EXIT_TBL = DEF_EXIT,
  parameter logic [NT*NS-1:0] TARGET_TBL = DEF_TARGET
) (
  input  logic clk,
  input  logic rst,
  input  stepCtrl_t ctrl,
  input  logic [NT-1:0] selTrans,
  output logic [NS-1:0] activeQ,
  output logic [NS-1:0] entryStb,
  output logic [NS-1:0] exitStb
);

  function automatic int parentOf(int s);
    return int'(PARENT_TBL[s*IW +: IW]);
  endfunction

  function automatic stateKind_e kindOf(int s);
    return stateKind_e'(KIND_TBL[2*s +: 2]);
  endfunction

  // default child per state: declared one, else lowest-numbered child
  function automatic logic [NS*IW-1:0] calcDefaults();
    logic [NS*IW-1:0] r;
    int d;
    r = '0;
    for (int s = 0; s < NS; s++) begin
      d = int'(INIT_TBL[s*IW +: IW]);
      if (d == 0) begin
        for (int c = NS - 1; c > s; c--) begin
          if (int'(PARENT_TBL[c*IW +: IW]) == s) d = c;
        end
      end
      r[s*IW +: IW] = IW'(d);
    end
    return r;
  endfunction

  function automatic logic [NS-1:0] childMaskOf(int p);
    logic [NS-1:0] m;
    m = '0;
    for (int c = 1; c < NS; c++) begin
      if (int'(PARENT_TBL[c*IW +: IW]) == p) m[c] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NS*IW-1:0] DEF_CHILD = calcDefaults();

  // entry set: upward from targets, then downward from parents
  function automatic logic [NS-1:0] completeEntry(
    input logic [NT-1:0] sel,
    input logic [NS-1:0] stay,
    input logic          initStep
  );
    logic [NS-1:0] up, ce, childUp, childStay;
    int p;
    up = '0;
    for (int t = 0; t < NT; t++) begin
      if (sel[t]) up = up | TARGET_TBL[t*NS +: NS];
    end
    for (int s = NS - 1; s >= 1; s--) begin
      if (up[s]) up[parentOf(s)] = 1'b1;
    end
    childUp   = '0;
    childStay = '0;
    for (int s = 1; s < NS; s++) begin
      if (up[s])   childUp[parentOf(s)]   = 1'b1;
      if (stay[s]) childStay[parentOf(s)] = 1'b1;
    end
    ce = up;
    ce[0] = ce[0] | initStep;
    for (int s = 1; s < NS; s++) begin
      p = parentOf(s);
      if (ce[p]) begin
        if (kindOf(p) == KIND_PARALLEL) begin
          ce[s] = 1'b1;
        end else if (kindOf(p) == KIND_COMPOUND &&
                     s == int'(DEF_CHILD[p*IW +: IW]) &&
                     !childUp[p] && !childStay[p]) begin
          ce[s] = 1'b1;
        end
      end
    end
    return ce;
  endfunction

  logic [NS-1:0] exitAny;
  logic [NS-1:0] stayVec;
  logic [NS-1:0] ceVec;
  logic [NS-1:0] nextVec;

  always_comb begin
    exitAny = '0;
    for (int t = 0; t < NT; t++) begin
      if (selTrans[t]) exitAny = exitAny | EXIT_TBL[t*NS +: NS];
    end
  end

  assign exitStb  = activeQ & exitAny;
  assign stayVec  = activeQ & ~exitStb;
  assign ceVec    = completeEntry(selTrans, stayVec, ctrl.initStep);
  assign entryStb = ceVec & (exitStb | ~activeQ);

  always_comb begin
    nextVec    = ceVec | stayVec;
    nextVec[0] = ~ctrl.done;
  end

  always_ff @(posedge clk) begin
    if (rst) activeQ <= '0;
    else     activeQ <= nextVec;
  end

  // R8: an entered state is active after the edge (root excluded)
  p_entry_sets_r8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.initStep |-> ((($past(entryStb) & ~activeQ) >> 1) == '0));

  // R8: an exited state not re-entered is gone after the edge
  p_exit_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.initStep |-> ((activeQ & $past(exitStb & ~entryStb)) == '0));

  genvar g;
  generate
    for (g = 1; g < NS; g++) begin : gParChild
      localparam int PG = int'(PARENT_TBL[g*IW +: IW]);
      if (KIND_TBL[2*PG +: 2] == 2'(KIND_PARALLEL)) begin : gChk
        // R4: a parallel parent entering drags this child along
        p_par_child_r4: assert property (@(posedge clk) disable iff (rst)
          entryStb[PG] |-> entryStb[g]);
      end
    end
    for (g = 0; g < NS; g++) begin : gCmpChild
      if (KIND_TBL[2*g +: 2] == 2'(KIND_COMPOUND)) begin : gChk
        localparam logic [NS-1:0] KIDS = childMaskOf(g);
        // R6: never two active children of one compound state
        p_one_child_r6: assert property (@(posedge clk) disable iff (rst)
          $countones(activeQ & KIDS) <= 1);
      end
    end
  endgenerate

endmodule

// File: rtl/scfg_engine.sv
module scfg_engine
  import scfg_pkg::*;
#(
  parameter int NS = DEF_NS,
  parameter int NT = DEF_NT,
  parameter int IW = DEF_IW,
  parameter logic [NS*IW-1:0] PARENT_TBL = DEF_PARENT,
  parameter logic [NS*2-1:0] KIND_TBL = DEF_KIND,
  parameter logic [NS*IW-1:0] INIT_TBL = DEF_INIT,
  parameter logic [NT*NS-1:0] EXIT_TBL = DEF_EXIT,
  parameter logic [NT*NS-1:0] TARGET_TBL = DEF_TARGET
) (
  input  logic clk,
  input  logic rst,
  input  logic [NT-1:0] selTrans,
  output logic [NS-1:0] activeVec,
  output logic [NS-1:0] entryStrobe,
  output logic [NS-1:0] exitStrobe,
  output logic completed
);

  stepCtrl_t ctrl;
  logic [NS-1:0] activeQ;

  scfg_ctrl #(
    .NS(NS), .IW(IW), .PARENT_TBL(PARENT_TBL), .KIND_TBL(KIND_TBL)
  ) uCtrl (
    .clk(clk), .rst(rst), .activeQ(activeQ), .ctrl(ctrl)
  );

  scfg_datapath #(
    .NS(NS), .NT(NT), .IW(IW), .PARENT_TBL(PARENT_TBL), .KIND_TBL(KIND_TBL),
    .INIT_TBL(INIT_TBL), .EXIT_TBL(EXIT_TBL), .TARGET_TBL(TARGET_TBL)
  ) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .selTrans(selTrans),
    .activeQ(activeQ), .entryStb(entryStrobe), .exitStb(exitStrobe)
  );

  assign activeVec = activeQ;
  assign completed = ctrl.done;

endmodule

// File: tb/sim_scfg_engine.sv
module sim_scfg_engine;

  localparam int NS = 10;
  localparam int NT = 9;
  // state numbering of the default chart
  localparam int ROOT = 0, PAR = 1, RA = 2, A1 = 3, A2 = 4, RB = 5, B1 = 6, B2 = 7, FIN = 8, SIDE = 9;
  localparam logic [NS-1:0] INIT_CFG = 10'b0001110111;
  localparam logic [NS-1:0] PAR_TREE = 10'b0011111110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0] selTrans = '0;
  logic [NS-1:0] activeVec, entryStrobe, exitStrobe;
  logic completed;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // bench model: region 0 parallel, 1 side state, 2 final
  int region = 0;
  int aLeaf = 1;
  int bLeaf = 0;
  bit rootOn = 1'b1;

  always #4 clk = ~clk;

  scfg_engine u0 (
    .clk(clk), .rst(rst), .selTrans(selTrans), .activeVec(activeVec),
    .entryStrobe(entryStrobe), .exitStrobe(exitStrobe), .completed(completed)
  );

  function automatic logic [NS-1:0] bitOf(int s);
    return NS'(1) << s;
  endfunction

  function automatic logic [NS-1:0] cfgOf(int rg, int a, int b, bit rootBit);
    logic [NS-1:0] v;
    if (rg == 0)
      v = bitOf(ROOT) | bitOf(PAR) | bitOf(RA) | bitOf(RB) |
          (a != 0 ? bitOf(A2) : bitOf(A1)) | (b != 0 ? bitOf(B2) : bitOf(B1));
    else if (rg == 1)
      v = bitOf(ROOT) | bitOf(SIDE);
    else
      v = (rootBit ? bitOf(ROOT) : '0) | bitOf(FIN);
    return v;
  endfunction

  task automatic chkVec(string req, string what, logic [NS-1:0] act, logic [NS-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chkBit(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // called at a negedge: drive, check strobes, cross one edge
  task automatic runStep(logic [NT-1:0] sel, logic [NS-1:0] expExit,
                         logic [NS-1:0] expEntry, string req);
    selTrans = sel;
    #2;
    chkVec("R2", "exit strobe", exitStrobe, expExit);
    chkVec(req, "entry strobe", entryStrobe, expEntry);
    @(posedge clk);
    @(negedge clk);
    selTrans = '0;
  endtask

  task automatic chkState(string req);
    chkVec(req, "active", activeVec, cfgOf(region, aLeaf, bLeaf, rootOn));
    chkBit("R9", "completed", completed, region == 2);
  endtask

  task automatic doReset();
    rst = 1'b1;
    selTrans = '0;
    repeat (3) @(negedge clk);
    chkVec("R1", "active in reset", activeVec, '0);
    chkBit("R1", "completed in reset", completed, 1'b0);
    rst = 1'b0;
    runStep('0, '0, INIT_CFG, "R1");
    region = 0; aLeaf = 1; bLeaf = 0; rootOn = 1'b1;
    chkState("R1");
  endtask

  // choice: 0 leaf toggles, 4 to final, 6 to side, 8 self re-entry of regA,
  // 7 side to parallel, 5 side to deep a1, 9 idle
  task automatic applyChoice(int choice, int ta, int tb);
    logic [NT-1:0] sel;
    logic [NS-1:0] ex, en, cur;
    string req;
    sel = '0; ex = '0; en = '0; req = "R8";
    cur = cfgOf(region, aLeaf, bLeaf, rootOn);
    if (region == 0) begin
      case (choice)
        0: begin
          req = "R6";
          if (ta != 0) begin
            sel[aLeaf != 0 ? 0 : 1] = 1'b1;
            ex |= bitOf(aLeaf != 0 ? A2 : A1);
            en |= bitOf(aLeaf != 0 ? A1 : A2);
          end
          if (tb != 0) begin
            sel[bLeaf != 0 ? 3 : 2] = 1'b1;
            ex |= bitOf(bLeaf != 0 ? B2 : B1);
            en |= bitOf(bLeaf != 0 ? B1 : B2);
          end
          runStep(sel, ex, en, req);
          if (ta != 0) aLeaf = 1 - aLeaf;
          if (tb != 0) bLeaf = 1 - bLeaf;
        end
        4: begin
          sel[4] = 1'b1;
          runStep(sel, cur & PAR_TREE, bitOf(FIN), "R3");
          region = 2; rootOn = 1'b1;
        end
        6: begin
          sel[6] = 1'b1;
          runStep(sel, cur & PAR_TREE, bitOf(SIDE), "R3");
          region = 1;
        end
        8: begin
          sel[8] = 1'b1;
          // regA exits and re-enters; its default child a2 follows
          runStep(sel, bitOf(RA) | bitOf(aLeaf != 0 ? A2 : A1),
                  bitOf(RA) | bitOf(A2), "R7");
          aLeaf = 1;
        end
        default: runStep('0, '0, '0, "R8");
      endcase
    end else if (region == 1) begin
      case (choice)
        7: begin
          sel[7] = 1'b1;
          // declared default a2, undeclared default falls to b1
          runStep(sel, bitOf(SIDE),
                  bitOf(PAR) | bitOf(RA) | bitOf(A2) | bitOf(RB) | bitOf(B1), "R5");
          region = 0; aLeaf = 1; bLeaf = 0;
        end
        5: begin
          sel[5] = 1'b1;
          // target a1 lifts regA and par, regB gets its default, no a2
          runStep(sel, bitOf(SIDE),
                  bitOf(PAR) | bitOf(RA) | bitOf(A1) | bitOf(RB) | bitOf(B1), "R3");
          region = 0; aLeaf = 0; bLeaf = 0;
        end
        default: runStep('0, '0, '0, "R8");
      endcase
    end else begin
      runStep('0, '0, '0, "R9");
      rootOn = 1'b0;
    end
    chkState(req);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int seedDummy;
    int r;
    seedDummy = $urandom(32'd4242);
    @(negedge clk);
    doReset();

    // directed corners
    applyChoice(0, 1, 1);   // R4 R6: both regions step together
    applyChoice(8, 0, 0);   // R7: exit and re-enter regA
    applyChoice(0, 1, 0);   // R6: a2 to a1, no default pulled
    applyChoice(6, 0, 0);   // R3: leave parallel tree
    applyChoice(5, 0, 0);   // R3 R4: deep target a1
    applyChoice(0, 0, 1);
    applyChoice(6, 0, 0);
    applyChoice(7, 0, 0);   // R5: default children
    applyChoice(0, 0, 1);   // b2 active before mid-run reset
    doReset();              // R1: reset from a non-default configuration
    applyChoice(4, 0, 0);   // R9: into top-level final
    applyChoice(9, 0, 0);   // R9: root drops
    applyChoice(9, 0, 0);   // R9: final holds alone
    doReset();

    for (int i = 0; i < 900; i++) begin
      if (region == 2) begin
        if (rootOn) applyChoice(9, 0, 0);
        else doReset();
      end else if (region == 0) begin
        r = int'($urandom % 12);
        if (r < 7) applyChoice(0, int'($urandom % 2), int'($urandom % 2));
        else if (r == 7) applyChoice(4, 0, 0);
        else if (r == 8) applyChoice(6, 0, 0);
        else if (r == 9) applyChoice(8, 0, 0);
        else applyChoice(9, 0, 0);
      end else begin
        r = int'($urandom % 3);
        applyChoice(r == 0 ? 7 : (r == 1 ? 5 : 9), 0, 0);
      end
    end
    finishRun();
  end

endmodule